// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM from power-on to a usable state before any ordinary access is allowed. Once the supply and clock are good, the memory must see only idle commands for a long delay. It must then have every bank closed, receive two refresh cycles and have its mode register written. Until that last step the mode register contents are unknown. The sequencer holds the command bus idle until its clock-stable input goes high. It counts out the power-up delay, then steps through precharge-all, two auto-refreshes and the mode load, with the required spacing after each. After that it raises a done flag that a memory controller uses to gate its own traffic.

All delays are parameters given in clock cycles. At 166 MHz a 100 us wait is 16,600 cycles; a small value can be used in simulation. Each post-command spacing parameter (precharge-to-command, refresh-to-command, mode-load-to-command) counts the command cycle itself and must be at least 2. The mode word is built from three parameters: burst length code, burst type and CAS latency.

Top module: `sdram_init_seq`

## Requirements
- R1: While rst_n is low, cmd is NOP (4'b0111, bit order cs_n, ras_n, cas_n, we_n), addr is all zero and init_done is 0.
- R2: Before init_done, any cycle in which clk_stable was low at the previous edge shows cmd NOP, and clk_stable low keeps the block waiting indefinitely.
- R3: If clk_stable is first sampled high at edge E0, cmd is NOP after E0 through the PWRUP_CYC-1 edges that follow. After edge E0+PWRUP_CYC, cmd shows precharge (4'b0010) for one cycle with addr bit 10 high and all other addr bits low.
- R4: The first auto-refresh (4'b0001) appears T_RP cycles after the precharge cycle, with NOP on every cycle between them.
- R5: The second auto-refresh appears T_RC cycles after the first, with NOP between.
- R6: The load-mode command (4'b0000) appears T_RC cycles after the second refresh, for one cycle. addr then carries burst length code in bits 2..0, burst type in bit 3 and CAS latency in bits 6..4, with all higher bits zero.
- R7: init_done rises T_MRD cycles after the load-mode cycle, with NOP between; each of the four commands occurs exactly once per sequence.
- R8: Once init_done is high it stays high, and cmd stays NOP with addr zero, whatever clk_stable does, until reset.
- R9: If clk_stable is sampled low at any point before init_done, the block returns to waiting. When clk_stable is next sampled high it repeats the whole sequence, including the full power-up delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_stable | input | 1 | High when supply and clock are stable |
| cmd | output | 4 | SDRAM command {cs_n, ras_n, cas_n, we_n} |
| addr | output | ADDR_W | SDRAM address bus |
| init_done | output | 1 | High once the sequence has completed |

## Verification
The hardest situations to reach are losses of clk_stable partway through the sequence. Such a loss must throw away a partly counted delay, or the refreshes already issued, and force a complete rerun. The bench drops clk_stable once during the power-up count and once in the gap after the first refresh. After each drop it raises the input again and checks the full expected trace cycle by cycle from the new start. A drop after completion is also applied, to show that done is unaffected.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int PWRUP_CYC = 16600,
  parameter int T_RP = 3,
  parameter int T_RC = 10,
  parameter int T_MRD = 2,
  parameter int ADDR_W = 12,
  parameter logic [2:0] BURST_LEN = 3'b011,
  parameter logic BURST_TYPE = 1'b0,
  parameter logic [2:0] CAS_LAT = 3'b011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_stable,
  output logic [3:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);
  localparam int TM1 = (T_RP > T_RC) ? T_RP : T_RC;
  localparam int TM2 = (TM1 > T_MRD) ? TM1 : T_MRD;
  localparam int TMAX = (TM2 > PWRUP_CYC) ? TM2 : PWRUP_CYC;
  localparam int CW = $clog2(TMAX + 1);
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;
  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'({CAS_LAT, BURST_TYPE, BURST_LEN});
  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << 10;

  typedef enum logic [3:0] {
    S_WAIT, S_PWR, S_PRE, S_TRP, S_REF1, S_TRC1, S_REF2, S_TRC2, S_LMR, S_TMRD, S_DONE
  } st_t;

  st_t st, nx;
  logic [CW-1:0] cnt, cnt_nx;
  wire zero = (cnt == '0);

  always_comb begin
    nx = st;
    cnt_nx = zero ? cnt : cnt - 1'b1;
    case (st)
      S_WAIT: if (clk_stable) begin nx = S_PWR; cnt_nx = CW'(PWRUP_CYC - 1); end
      S_PWR:  if (zero) nx = S_PRE;
      S_PRE:  begin nx = S_TRP; cnt_nx = CW'(T_RP - 2); end
      S_TRP:  if (zero) nx = S_REF1;
      S_REF1: begin nx = S_TRC1; cnt_nx = CW'(T_RC - 2); end
      S_TRC1: if (zero) nx = S_REF2;
      S_REF2: begin nx = S_TRC2; cnt_nx = CW'(T_RC - 2); end
      S_TRC2: if (zero) nx = S_LMR;
      S_LMR:  begin nx = S_TMRD; cnt_nx = CW'(T_MRD - 2); end
      S_TMRD: if (zero) nx = S_DONE;
      default: nx = S_DONE;
    endcase
    if (st != S_DONE && !clk_stable) nx = S_WAIT;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= S_WAIT;
      cnt <= '0;
    end else begin
      st  <= nx;
      cnt <= cnt_nx;
    end

  assign cmd = (st == S_PRE)  ? C_PRE :
               (st == S_REF1 || st == S_REF2) ? C_REF :
               (st == S_LMR)  ? C_LMR : C_NOP;
  assign addr = (st == S_PRE) ? ALL_BANKS :
                (st == S_LMR) ? MODE_WORD : '0;
  assign init_done = (st == S_DONE);
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int ADDR_W = 12,
  parameter logic [2:0] BURST_LEN = 3'b011,
  parameter logic BURST_TYPE = 1'b0,
  parameter logic [2:0] CAS_LAT = 3'b011
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_stable,
  input logic [3:0]        cmd,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done
);
  localparam logic [3:0] C_NOP = 4'b0111;

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |-> (cmd == C_NOP && !init_done));
  p_nop_unstable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_stable && !init_done) |=> cmd == C_NOP);
  p_pre_allbanks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 4'b0010 |-> addr == (ADDR_W'(1) << 10));
  p_mode_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 4'b0000 |-> addr == ADDR_W'({CAS_LAT, BURST_TYPE, BURST_LEN}));
  p_single_cycle_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd != C_NOP |=> cmd == C_NOP);
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cmd == C_NOP && addr == '0));
endmodule

bind sdram_init_seq sdram_init_chk #(
  .ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN), .BURST_TYPE(BURST_TYPE), .CAS_LAT(CAS_LAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_stable(clk_stable),
  .cmd(cmd), .addr(addr), .init_done(init_done)
);

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;
  localparam int PW = 50, RP = 3, RC = 5, MRD = 2;
  localparam int N_PRE = PW, N_REF1 = PW + RP, N_REF2 = PW + RP + RC;
  localparam int N_LMR = PW + RP + 2 * RC, N_DONE = PW + RP + 2 * RC + MRD;

  logic clk = 0, rst_n = 0, clk_stable = 0;
  logic [3:0] cmd;
  logic [11:0] addr;
  logic init_done;
  int total = 0, bad = 0;

  sdram_init_seq #(.PWRUP_CYC(PW), .T_RP(RP), .T_RC(RC), .T_MRD(MRD), .ADDR_W(12),
    .BURST_LEN(3'b010), .BURST_TYPE(1'b1), .CAS_LAT(3'b010)) dut (
    .clk(clk), .rst_n(rst_n), .clk_stable(clk_stable),
    .cmd(cmd), .addr(addr), .init_done(init_done));

  always #5 clk = ~clk;

  task automatic chk(string req, logic [3:0] ec, logic [11:0] ea, logic ed);
    total++;
    if (cmd !== ec || addr !== ea || init_done !== ed) begin
      bad++;
      $display("FAIL %s t=%0t: cmd=%b addr=%h done=%b expected cmd=%b addr=%h done=%b",
               req, $time, cmd, addr, init_done, ec, ea, ed);
    end
  endtask

  function automatic string tag_of(int n);
    if (n <= N_PRE) return "R3";
    if (n <= N_REF1) return "R4";
    if (n <= N_REF2) return "R5";
    if (n <= N_LMR) return "R6";
    return "R7";
  endfunction

  task automatic chk_cycle(int n);
    logic [3:0] ec = 4'b0111;
    logic [11:0] ea = 12'h000;
    if (n == N_PRE) begin ec = 4'b0010; ea = 12'h400; end
    else if (n == N_REF1 || n == N_REF2) ec = 4'b0001;
    else if (n == N_LMR) begin ec = 4'b0000; ea = 12'h02A; end
    chk(tag_of(n), ec, ea, n >= N_DONE);
  endtask

  task automatic do_reset();
    clk_stable = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run_trace(int upto);
    clk_stable = 1;
    for (int n = 0; n < upto; n++) begin
      @(negedge clk);
      chk_cycle(n);
    end
  endtask

  task automatic t_reset();
    rst_n = 0;
    clk_stable = 1;
    repeat (4) begin @(negedge clk); chk("R1", 4'b0111, 12'h000, 1'b0); end
    clk_stable = 0;
    rst_n = 1;
  endtask

  task automatic t_wait_stable();
    repeat (40) begin @(negedge clk); chk("R2", 4'b0111, 12'h000, 1'b0); end
  endtask

  task automatic t_sequence();
    run_trace(N_DONE + 4);
  endtask

  task automatic t_after_done();
    clk_stable = 0;
    repeat (10) begin @(negedge clk); chk("R8", 4'b0111, 12'h000, 1'b1); end
    clk_stable = 1;
    repeat (5) begin @(negedge clk); chk("R8", 4'b0111, 12'h000, 1'b1); end
  endtask

  task automatic t_restart(int drop_at);
    do_reset();
    run_trace(drop_at);
    clk_stable = 0;
    repeat (6) begin @(negedge clk); chk("R9", 4'b0111, 12'h000, 1'b0); end
    run_trace(N_DONE + 3);
  endtask

  initial begin
    t_reset();
    t_wait_stable();
    t_sequence();
    t_after_done();
    t_restart(30);
    t_restart(N_REF1 + 2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule